// File: doc/BRIEF.md
# Dual-lane 8b/10b decoder

This block turns a 20-bit word holding two 10-bit 8b/10b code groups into two data bytes. Each byte comes with a flag that marks it as a control character. Each byte also gets two fault flags: one for a code group that is not in the code table, and one for a group that is legal but was sent with the wrong running disparity. Both lanes are decoded in the same clock cycle. The low lane's ending disparity feeds the high lane. The disparity left after the high lane is stored in a register and is used by the low lane of the next word.

The block sits after word alignment in a receive path. A decode-enable input lets the receive path carry unencoded traffic. When it is low, the 20 received bits go to the output untouched. The number of lanes is a parameter; the default is two.

Top module: `dual_8b10b_dec`

## Requirements
- R1: While reset is held, every output is zero. The stored running disparity resets to negative, so the first group after reset is judged against the negative-disparity column.
- R2: Every output is registered. A word presented before a rising clock edge shows its result after that edge.
- R3: The low group is in code_in[9:0] and the high group in code_in[19:10]. Within a group, bit 9 is a, then b, c, d, e, i, f, g, h, and bit 0 is j. Lane n's byte is data_out[8n+7:8n], with its flags at bit n of ctrl_out, code_err and disp_err. Within a byte, bits [4:0] hold EDCBA (A is bit 0) and bits [7:5] hold HGF.
- R4: All 256 data characters decode to their byte value, with ctrl_out, code_err and disp_err all clear, when sent with the correct disparity.
- R5: The twelve control characters decode with their lane's ctrl_out bit set: K28.0 to K28.7 (byte values 1C, 3C, 5C, 7C, 9C, BC, DC, FC) and K23.7, K27.7, K29.7, K30.7 (F7, FB, FD, FE).
- R6: A 10-bit group that matches no entry of the code table in either disparity column sets its lane's code_err. Examples are a 6-bit part 000000, a 4-bit part 1111, or the alternate 4-bit form of x.7 after a 6-bit part that does not call for it. That lane's data_out byte and ctrl_out bit are then undefined, and its disp_err stays clear.
- R7: A legal group that matches only the opposite column of the current running disparity sets its lane's disp_err and still decodes to its byte. A group that is the same in both columns never sets disp_err.
- R8: The high lane's starting disparity in a word is the disparity left after the low lane of that same word.
- R9: Running disparity advances from the received bits, even after a fault. For each 6-bit or 4-bit part: more ones than zeros makes it positive, fewer makes it negative. The balanced parts 000111 and 0011 make it positive, 111000 and 1100 make it negative, and any other balanced part leaves it unchanged.
- R10: With dec_en low, data_out copies code_in one cycle later, all flags are zero, and the stored running disparity holds its value.
- R11: While decoding, the bits of data_out above the decoded bytes (data_out[19:16] by default) are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_en | input | 1 | 1 = decode, 0 = pass the raw word through |
| code_in | input | 20 | Two received code groups, low lane in bits [9:0] |
| data_out | output | 20 | Decoded bytes in [15:0]; the raw word when bypassed |
| ctrl_out | output | 2 | Per-lane control-character flag |
| code_err | output | 2 | Per-lane flag for a group not in the code table |
| disp_err | output | 2 | Per-lane running-disparity mismatch flag |

## Verification
The properties assume that dec_en and code_in carry known values at every rising edge once reset is released. They assume nothing about whether a word holds legal code groups, because any 20-bit pattern is a valid input. The control-character property only applies to lanes without a code error, since the decoded byte of a faulty lane is undefined. The stimulus changes inputs only on falling edges and holds reset for several cycles with known inputs. Its code groups come from an encoder in the bench that tracks disparity from the bits actually sent, including deliberately wrong-column and out-of-table groups.

// File: rtl/cdec_pkg.sv
package cdec_pkg;

   localparam int GRP_W  = 10;
   localparam int BYTE_W = 8;

   // 5b->6b encoding, negative-disparity column (a is bit 5)
   function automatic logic [5:0] enc6(input logic [4:0] x, input logic rd);
      logic [5:0] c;
      case (x)
         5'd0:  c = 6'b100111;  5'd1:  c = 6'b011101;
         5'd2:  c = 6'b101101;  5'd3:  c = 6'b110001;
         5'd4:  c = 6'b110101;  5'd5:  c = 6'b101001;
         5'd6:  c = 6'b011001;  5'd7:  c = 6'b111000;
         5'd8:  c = 6'b111001;  5'd9:  c = 6'b100101;
         5'd10: c = 6'b010101;  5'd11: c = 6'b110100;
         5'd12: c = 6'b001101;  5'd13: c = 6'b101100;
         5'd14: c = 6'b011100;  5'd15: c = 6'b010111;
         5'd16: c = 6'b011011;  5'd17: c = 6'b100011;
         5'd18: c = 6'b010011;  5'd19: c = 6'b110010;
         5'd20: c = 6'b001011;  5'd21: c = 6'b101010;
         5'd22: c = 6'b011010;  5'd23: c = 6'b111010;
         5'd24: c = 6'b110011;  5'd25: c = 6'b100110;
         5'd26: c = 6'b010110;  5'd27: c = 6'b110110;
         5'd28: c = 6'b001110;  5'd29: c = 6'b101110;
         5'd30: c = 6'b011110;  default: c = 6'b101011;
      endcase
      if (rd && ($countones(c) != 3 || x == 5'd7)) c = ~c;
      return c;
   endfunction

   // 3b->4b encoding; alt selects the alternate form of x.7
   function automatic logic [3:0] enc4(input logic [2:0] y, input logic alt, input logic rd6);
      logic [3:0] c;
      case (y)
         3'd0: c = 4'b1011;  3'd1: c = 4'b1001;
         3'd2: c = 4'b0101;  3'd3: c = 4'b1100;
         3'd4: c = 4'b1101;  3'd5: c = 4'b1010;
         3'd6: c = 4'b0110;  default: c = alt ? 4'b0111 : 4'b1110;
      endcase
      if (rd6 && ($countones(c) != 2 || y == 3'd3)) c = ~c;
      return c;
   endfunction

   function automatic logic rd_sub6(input logic rd, input logic [5:0] s);
      logic r;
      r = rd;
      if ($countones(s) > 3)       r = 1'b1;
      else if ($countones(s) < 3)  r = 1'b0;
      else if (s == 6'b000111)     r = 1'b1;
      else if (s == 6'b111000)     r = 1'b0;
      return r;
   endfunction

   function automatic logic rd_sub4(input logic rd, input logic [3:0] s);
      logic r;
      r = rd;
      if ($countones(s) > 2)       r = 1'b1;
      else if ($countones(s) < 2)  r = 1'b0;
      else if (s == 4'b0011)       r = 1'b1;
      else if (s == 4'b1100)       r = 1'b0;
      return r;
   endfunction

   function automatic logic rd_after(input logic rd, input logic [GRP_W-1:0] g);
      return rd_sub4(rd_sub6(rd, g[9:4]), g[3:0]);
   endfunction

   // full group for a byte at a given starting disparity
   function automatic logic [GRP_W-1:0] enc10(input logic [BYTE_W-1:0] b, input logic k, input logic rd);
      logic [4:0] x;
      logic [2:0] y;
      logic [5:0] s6;
      logic       r6, alt;
      logic [GRP_W-1:0] c;
      x = b[4:0];
      y = b[7:5];
      if (k && x == 5'd28) begin
         c = {6'b001111, enc4(y, y == 3'd7, 1'b1)};
         return rd ? ~c : c;
      end
      s6  = enc6(x, rd);
      r6  = rd_sub6(rd, s6);
      alt = (y == 3'd7) && (k || (!r6 && x inside {5'd17, 5'd18, 5'd20})
                              || (r6 && x inside {5'd11, 5'd13, 5'd14}));
      return {s6, enc4(y, alt, r6)};
   endfunction

endpackage

// File: rtl/cdec_lookup.sv
module cdec_lookup
   import cdec_pkg::*;
(
   input  logic [GRP_W-1:0] grp,
   output logic [4:0]       x,
   output logic [2:0]       y,
   output logic             k
);
   logic [5:0] s6;
   logic [3:0] s4, f;
   logic       k28, alt7;

   assign s6   = grp[9:4];
   assign s4   = grp[3:0];
   assign k28  = (s6 == 6'b001111) || (s6 == 6'b110000);
   assign alt7 = (s4 == 4'b0111) || (s4 == 4'b1000);
   // the positive K28 prefix carries complemented 4-bit parts
   assign f    = (s6 == 6'b110000) ? ~s4 : s4;

   always_comb begin
      x = '0;
      for (int v = 0; v < 32; v++) begin
         if (s6 == enc6(5'(v), 1'b0) || s6 == enc6(5'(v), 1'b1)) x = 5'(v);
      end
      if (k28) x = 5'd28;
   end

   always_comb begin
      case (f)
         4'b1011, 4'b0100:                     y = 3'd0;
         4'b1001:                              y = 3'd1;
         4'b0101:                              y = 3'd2;
         4'b1100, 4'b0011:                     y = 3'd3;
         4'b1101, 4'b0010:                     y = 3'd4;
         4'b1010:                              y = 3'd5;
         4'b0110:                              y = 3'd6;
         4'b1110, 4'b0001, 4'b0111, 4'b1000:   y = 3'd7;
         default:                              y = 3'd0;
      endcase
   end

   assign k = k28 || (alt7 && (x inside {5'd23, 5'd27, 5'd29, 5'd30}));
endmodule

// File: rtl/cdec_lane.sv
module cdec_lane
   import cdec_pkg::*;
(
   input  logic [GRP_W-1:0]  grp,
   input  logic              rd_in,
   output logic [BYTE_W-1:0] byte_o,
   output logic              k_o,
   output logic              err_o,
   output logic              derr_o,
   output logic              rd_out
);
   logic [4:0]       x;
   logic [2:0]       y;
   logic             k;
   logic [GRP_W-1:0] neg_form, pos_form;
   logic             legal;

   cdec_lookup u_lookup (.grp(grp), .x(x), .y(y), .k(k));

   assign byte_o   = {y, x};
   assign k_o      = k;
   // a group is legal only if re-encoding the decoded byte reproduces it
   assign neg_form = enc10({y, x}, k, 1'b0);
   assign pos_form = enc10({y, x}, k, 1'b1);
   assign legal    = (grp == neg_form) || (grp == pos_form);
   assign err_o    = !legal;
   assign derr_o   = legal && (grp != (rd_in ? pos_form : neg_form));
   assign rd_out   = rd_after(rd_in, grp);
endmodule

// File: rtl/dual_8b10b_dec.sv
module dual_8b10b_dec
   import cdec_pkg::*;
#(
   parameter int NUM_LANES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       dec_en,
   input  logic [NUM_LANES*10-1:0]    code_in,
   output logic [NUM_LANES*10-1:0]    data_out,
   output logic [NUM_LANES-1:0]       ctrl_out,
   output logic [NUM_LANES-1:0]       code_err,
   output logic [NUM_LANES-1:0]       disp_err
);
   localparam int CODE_W = NUM_LANES * GRP_W;
   localparam int DATA_W = NUM_LANES * BYTE_W;
   localparam int PAD_W  = CODE_W - DATA_W;

   if (NUM_LANES < 1 || NUM_LANES > 8) begin : g_bad_lanes
      $error("dual_8b10b_dec: NUM_LANES must lie in 1..8");
   end

   logic [DATA_W-1:0]    dec_bus;
   logic [NUM_LANES-1:0] k_bus, err_bus, derr_bus;
   logic [NUM_LANES:0]   rd_chain;
   logic                 rd_q;

   assign rd_chain[0] = rd_q;

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      cdec_lane u_lane (
         .grp    (code_in[g*GRP_W +: GRP_W]),
         .rd_in  (rd_chain[g]),
         .byte_o (dec_bus[g*BYTE_W +: BYTE_W]),
         .k_o    (k_bus[g]),
         .err_o  (err_bus[g]),
         .derr_o (derr_bus[g]),
         .rd_out (rd_chain[g+1])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_out <= '0;
         ctrl_out <= '0;
         code_err <= '0;
         disp_err <= '0;
         rd_q     <= 1'b0;
      end else if (dec_en) begin
         data_out <= {{PAD_W{1'b0}}, dec_bus};
         ctrl_out <= k_bus;
         code_err <= err_bus;
         disp_err <= derr_bus;
         rd_q     <= rd_chain[NUM_LANES];
      end else begin
         data_out <= code_in;
         ctrl_out <= '0;
         code_err <= '0;
         disp_err <= '0;
      end
   end
endmodule

// File: rtl/cdec_chk.sv
module cdec_chk #(
   parameter int NUM_LANES = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    dec_en,
   input logic [NUM_LANES*10-1:0] code_in,
   input logic [NUM_LANES*10-1:0] data_out,
   input logic [NUM_LANES-1:0]    ctrl_out,
   input logic [NUM_LANES-1:0]    code_err,
   input logic [NUM_LANES-1:0]    disp_err,
   input logic                    rd_q
);
   localparam int CODE_W = NUM_LANES * 10;
   localparam int DATA_W = NUM_LANES * 8;

   p_reset_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (data_out == '0 && ctrl_out == '0 && code_err == '0 && disp_err == '0));

   p_bypass_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_en |=> (data_out == $past(code_in) && ctrl_out == '0 && code_err == '0 && disp_err == '0));

   p_bypass_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_en |=> $stable(rd_q));

   p_upper_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      dec_en |=> data_out[CODE_W-1:DATA_W] == '0);

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane_chk
      p_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !(code_err[g] && disp_err[g]));

      p_ctrl_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (ctrl_out[g] && !code_err[g]) |->
            (data_out[g*8 +: 5] == 5'd28 ||
             data_out[g*8 +: 8] inside {8'hF7, 8'hFB, 8'hFD, 8'hFE}));
   end
endmodule

bind dual_8b10b_dec cdec_chk #(.NUM_LANES(NUM_LANES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .dec_en   (dec_en),
   .code_in  (code_in),
   .data_out (data_out),
   .ctrl_out (ctrl_out),
   .code_err (code_err),
   .disp_err (disp_err),
   .rd_q     (rd_q)
);

// File: tb/dual_8b10b_dec_bench.sv
`timescale 1ns/1ps
module dual_8b10b_dec_bench;
   localparam time TCK = 20ns;   // 50 MHz

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dec_en = 1'b1;
   logic [19:0] code_in = '0;
   logic [19:0] data_out;
   logic [1:0]  ctrl_out, code_err, disp_err;

   always #(TCK/2) clk = ~clk;

   dual_8b10b_dec #(.NUM_LANES(2)) u_dual_8b10b_dec (
      .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .code_in(code_in),
      .data_out(data_out), .ctrl_out(ctrl_out), .code_err(code_err), .disp_err(disp_err)
   );

   typedef struct {
      logic [19:0] data;
      logic [19:0] mask;
      logic [1:0]  ctrl;
      logic [1:0]  cmask;
      logic [1:0]  err;
      logic [1:0]  derr;
      logic        dec;
      string       tag;
   } exp_t;

   exp_t q[$];
   logic tok = 1'b0;
   logic brd = 1'b0;      // bench running disparity, 0 = negative
   int   total = 0;
   int   bad = 0;

   // positive-disparity column of the 5b/6b table
   function automatic logic [5:0] t6pos(input logic [4:0] x);
      case (x)
         5'd0:  return 6'b011000;  5'd1:  return 6'b100010;
         5'd2:  return 6'b010010;  5'd3:  return 6'b110001;
         5'd4:  return 6'b001010;  5'd5:  return 6'b101001;
         5'd6:  return 6'b011001;  5'd7:  return 6'b000111;
         5'd8:  return 6'b000110;  5'd9:  return 6'b100101;
         5'd10: return 6'b010101;  5'd11: return 6'b110100;
         5'd12: return 6'b001101;  5'd13: return 6'b101100;
         5'd14: return 6'b011100;  5'd15: return 6'b101000;
         5'd16: return 6'b100100;  5'd17: return 6'b100011;
         5'd18: return 6'b010011;  5'd19: return 6'b110010;
         5'd20: return 6'b001011;  5'd21: return 6'b101010;
         5'd22: return 6'b011010;  5'd23: return 6'b000101;
         5'd24: return 6'b001100;  5'd25: return 6'b100110;
         5'd26: return 6'b010110;  5'd27: return 6'b001001;
         5'd28: return 6'b001110;  5'd29: return 6'b010001;
         5'd30: return 6'b100001;  default: return 6'b010100;
      endcase
   endfunction

   function automatic logic [3:0] t4pos(input logic [2:0] y, input logic alt);
      case (y)
         3'd0: return 4'b0100;  3'd1: return 4'b1001;
         3'd2: return 4'b0101;  3'd3: return 4'b0011;
         3'd4: return 4'b0010;  3'd5: return 4'b1010;
         3'd6: return 4'b0110;  default: return alt ? 4'b1000 : 4'b0001;
      endcase
   endfunction

   // R9 rule applied to one sub-block of n bits
   function automatic logic part_rd(input logic rd, input int ones, input int half,
                                    input logic fpos, input logic fneg);
      if (ones > half) return 1'b1;
      if (ones < half) return 1'b0;
      if (fpos) return 1'b1;
      if (fneg) return 1'b0;
      return rd;
   endfunction

   function automatic logic next_rd(input logic rd, input logic [9:0] g);
      logic r;
      r = part_rd(rd, $countones(g[9:4]), 3, g[9:4] == 6'b000111, g[9:4] == 6'b111000);
      return part_rd(r, $countones(g[3:0]), 2, g[3:0] == 4'b0011, g[3:0] == 4'b1100);
   endfunction

   function automatic logic [9:0] encode(input logic [7:0] b, input logic k, input logic rd);
      logic [4:0] x;
      logic [2:0] y;
      logic [5:0] s6;
      logic [3:0] s4;
      logic       r6, alt;
      x = b[4:0];
      y = b[7:5];
      if (k && x == 5'd28) begin
         if (rd) return ~{6'b001111, t4pos(y, y == 3'd7)};
         return {6'b001111, t4pos(y, y == 3'd7)};
      end
      s6 = t6pos(x);
      if (!rd && ($countones(s6) != 3 || x == 5'd7)) s6 = ~s6;
      r6 = part_rd(rd, $countones(s6), 3, s6 == 6'b000111, s6 == 6'b111000);
      alt = (y == 3'd7) && (k || (!r6 && (x == 5'd17 || x == 5'd18 || x == 5'd20))
                              || (r6 && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
      s4 = t4pos(y, alt);
      if (!r6 && ($countones(s4) != 2 || y == 3'd3)) s4 = ~s4;
      return {s6, s4};
   endfunction

   task automatic drive(input logic en, input logic [19:0] w, input exp_t e);
      @(negedge clk);
      dec_en  = en;
      code_in = w;
      q.push_back(e);
      tok = 1'b1;
   endtask

   task automatic idle();
      @(negedge clk);
      tok = 1'b0;
   endtask

   // push two already-formed groups, expected decode given; brd follows the bits
   task automatic send_groups(input logic [9:0] g0, input logic [9:0] g1,
                              input logic [7:0] d0, input logic [7:0] d1,
                              input logic k0, input logic k1,
                              input logic [1:0] err, input logic [1:0] derr,
                              input logic [1:0] care, input string tag);
      exp_t e;
      e.data  = {4'h0, d1, d0};
      e.mask  = {4'h0, care[1] ? 8'hFF : 8'h00, care[0] ? 8'hFF : 8'h00};
      e.ctrl  = {k1, k0};
      e.cmask = care;
      e.err   = err;
      e.derr  = derr;
      e.dec   = 1'b1;
      e.tag   = tag;
      brd = next_rd(next_rd(brd, g0), g1);
      drive(1'b1, {g1, g0}, e);
   endtask

   task automatic send_pair(input logic [7:0] b0, input logic k0,
                            input logic [7:0] b1, input logic k1, input string tag);
      logic [9:0] g0, g1;
      logic r;
      g0 = encode(b0, k0, brd);
      r  = next_rd(brd, g0);
      g1 = encode(b1, k1, r);
      send_groups(g0, g1, b0, b1, k0, k1, 2'b00, 2'b00, 2'b11, tag);
   endtask

   task automatic send_bypass(input logic [19:0] w, input string tag);
      exp_t e;
      e.data = w;  e.mask = '1;  e.ctrl = '0;  e.cmask = 2'b11;
      e.err = '0;  e.derr = '0;  e.dec = 1'b0;  e.tag = tag;
      drive(1'b0, w, e);
   endtask

   task automatic check_item();
      exp_t e;
      total++;
      if (q.size() == 0) begin
         bad++;
         $display("FAIL R2: result with no pending word, actual data=%h expected none", data_out);
         return;
      end
      e = q.pop_front();
      if (((data_out ^ e.data) & e.mask) != '0 || ((ctrl_out ^ e.ctrl) & e.cmask) != '0 ||
          code_err != e.err || disp_err != e.derr) begin
         bad++;
         $display("FAIL %s: actual data=%h ctrl=%b err=%b derr=%b expected data=%h ctrl=%b err=%b derr=%b (mask %h)",
                  e.tag, data_out, ctrl_out, code_err, disp_err, e.data, e.ctrl, e.err, e.derr, e.mask);
      end
      if (e.dec) begin
         total++;   // R11: upper bits zero while decoding
         if (data_out[19:16] != 4'h0) begin
            bad++;
            $display("FAIL R11: actual upper=%h expected upper=0", data_out[19:16]);
         end
      end
   endtask

   // monitor: R2, result of the word taken at this edge is checked just after it
   always @(posedge clk) begin
      if (tok) begin
         #2ns;
         check_item();
      end
   end

   initial begin
      fork
         begin : run
            logic [7:0] klist [12];
            klist = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC,
                      8'hDC, 8'hFC, 8'hF7, 8'hFB, 8'hFD, 8'hFE};
            repeat (3) @(negedge clk);
            // R1: outputs zero during reset
            total++;
            if (data_out != '0 || ctrl_out != '0 || code_err != '0 || disp_err != '0) begin
               bad++;
               $display("FAIL R1: actual data=%h ctrl=%b err=%b derr=%b expected all zero",
                        data_out, ctrl_out, code_err, disp_err);
            end
            @(negedge clk);
            rst_n = 1'b1;

            // R1 R2 R3: K28.5 in positive form as first group flags a disparity error
            send_groups(10'b1100000101, encode(8'hB5, 1'b0, 1'b0), 8'hBC, 8'hB5,
                        1'b1, 1'b0, 2'b00, 2'b01, 2'b11, "R1 R2 R3");
            // R3: literal K28.5 negative form on the low lane, literal D.0.0 positive on high
            send_groups(10'b0011111010, 10'b0110001011, 8'hBC, 8'h00,
                        1'b1, 1'b0, 2'b00, 2'b00, 2'b11, "R3");

            // R4 R8 R9: every data byte, high lane follows low lane's disparity
            for (int b = 0; b < 256; b++) send_pair(8'(b), 1'b0, 8'(255 - b), 1'b0, "R4 R8 R9");

            // R5: every control character on both lanes, with data mixed in
            for (int i = 0; i < 12; i++) send_pair(klist[i], 1'b1, klist[11 - i], 1'b1, "R5");
            for (int i = 0; i < 12; i++) send_pair(8'h4A, 1'b0, klist[i], 1'b1, "R5 R8");

            // R8: low group leaves positive disparity, high lane must use it
            brd = 1'b0;
            send_pair(8'h00, 1'b0, 8'h00, 1'b0, "R8");
            send_pair(8'hBC, 1'b1, 8'h00, 1'b0, "R8");

            // R7: wrong-column groups on each lane
            begin
               logic [9:0] g0, g1;
               logic r;
               logic [7:0] blist [3];
               blist = '{8'h00, 8'h07, 8'h83};
               for (int i = 0; i < 3; i++) begin
                  g0 = encode(blist[i], 1'b0, ~brd);
                  r  = next_rd(brd, g0);
                  g1 = encode(8'h55, 1'b0, r);
                  send_groups(g0, g1, blist[i], 8'h55, 1'b0, 1'b0, 2'b00,
                              (g0 != encode(blist[i], 1'b0, brd)) ? 2'b01 : 2'b00, 2'b11, "R7");
                  g0 = encode(8'h21, 1'b0, brd);
                  r  = next_rd(brd, g0);
                  g1 = encode(blist[i], 1'b0, ~r);
                  send_groups(g0, g1, 8'h21, blist[i], 1'b0, 1'b0, 2'b00,
                              (g1 != encode(blist[i], 1'b0, r)) ? 2'b10 : 2'b00, 2'b11, "R7");
               end
               // R7: D.5.5 is identical in both columns, never a disparity error
               g0 = encode(8'hA5, 1'b0, ~brd);
               r  = next_rd(brd, g0);
               g1 = encode(8'hA5, 1'b0, ~r);
               send_groups(g0, g1, 8'hA5, 8'hA5, 1'b0, 1'b0, 2'b00, 2'b00, 2'b11, "R7");
               send_pair(8'h00, 1'b0, 8'h07, 1'b0, "R7 R9");

               // R6: groups outside the table, then R9 recovery from received bits
               r  = next_rd(brd, 10'b0000001011);
               g1 = encode(8'h3A, 1'b0, r);
               send_groups(10'b0000001011, g1, 8'h00, 8'h3A, 1'b0, 1'b0, 2'b01, 2'b00, 2'b10, "R6");
               send_pair(8'h00, 1'b0, 8'h00, 1'b0, "R6 R9");
               g0 = encode(8'h12, 1'b0, brd);
               r  = next_rd(brd, g0);
               send_groups(g0, 10'b1010011111, 8'h12, 8'h00, 1'b0, 1'b0, 2'b10, 2'b00, 2'b01, "R6");
               send_pair(8'h00, 1'b0, 8'h00, 1'b0, "R6 R9");
               send_groups(10'b1000111000, 10'b1100110111, 8'h00, 8'h00, 1'b0, 1'b0,
                           2'b11, 2'b00, 2'b00, "R6");
               send_pair(8'h00, 1'b0, 8'h1C, 1'b1, "R6 R9");
               send_groups(10'b1111110000, 10'b0000000000, 8'h00, 8'h00, 1'b0, 1'b0,
                           2'b11, 2'b00, 2'b00, "R6");
               send_pair(8'h00, 1'b0, 8'h00, 1'b0, "R6 R9");
            end

            // R10: raw pass-through, disparity held across it
            send_bypass(20'hABCDE, "R10");
            send_bypass(20'h00000, "R10");
            send_bypass(20'hFFFFF, "R10");
            for (int i = 0; i < 4; i++) send_bypass(20'($urandom), "R10");
            send_pair(8'h00, 1'b0, 8'h00, 1'b0, "R10");
            send_pair(8'h07, 1'b0, 8'h00, 1'b0, "R10");

            idle();
            repeat (3) @(negedge clk);
         end
         begin : watchdog
            #(TCK * 100000);
            total++;
            bad++;
            $display("FAIL R2: watchdog expired, actual pending=%0d expected 0", q.size());
         end
      join_any
      disable fork;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule